// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of software-visible control words behind a simple 32-bit register bus. Its byte-address window is 4 KiB. Only the lower 512 words of that window have storage, and the word index is the byte offset divided by four. Every selected access finishes in one cycle. Read data is registered and appears in the cycle after the read.

Two addresses do more than store a value. A write to the command offset 0xF00 lies outside the storage range. Such a write is not stored, but certain data values raise a one-cycle platform reset request or shutdown request. Three status words, at byte offsets 0x100, 0x108 and 0x10C, always read back with bits 29 and 28 forced high. The stored word does not change. Any access beyond the storage range raises a one-cycle bad-access pulse, so the surrounding logic can count such accesses.

On reset, four words are loaded with fixed identification and configuration values. All other words load zero.

Top module: `sysctl_regbank`

## Requirements
- R1: A selected write (sel=1, we=1) at a byte offset below 0x800 stores the data at word index offset/4. A later selected read (sel=1, we=0) of the same offset returns it on rdata in the cycle after the read.
- R2: After reset, rdata, rst_req, off_req and bad_acc are 0. Word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds zero.
- R3: A selected write at byte offset 0x800 or above stores nothing. In the cycle after the write, bad_acc is 1 for exactly one cycle.
- R4: A selected read at byte offset 0x800 or above returns rdata=0 in the next cycle, with bad_acc=1 for that one cycle.
- R5: A selected write at byte offset 0xF00 with data 1 or 2 makes rst_req 1 for the one cycle after the write.
- R6: A selected write at byte offset 0xF00 with data 3 makes off_req 1 for the one cycle after the write. Any other data, or any other offset, raises neither request.
- R7: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. A read at 0x104 returns the stored word unchanged.
- R8: Cycles with sel=0 change no word and raise no pulse. rdata keeps its value through unselected cycles and through writes.
- R9: bad_acc stays 0 for every access below byte offset 0x800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus select, an access happens this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle platform reset request |
| off_req | output | 1 | One-cycle shutdown request |
| bad_acc | output | 1 | One-cycle out-of-range access flag |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 32-bit data and 512 storage words. With these values the last stored word (0x7FC) is reachable. The first missing word (0x800) aliases word 0 under a truncated index, so a write there is followed by a read of word 0 to show it was dropped. The command offset and the top of the window can both be reached. A reset in the middle of the run shows that the preset words come back and user data is cleared.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  // Status words that read back with forced bits
  localparam int N_FORCE = 3;
  localparam logic [11:0] FORCE_OFFS [N_FORCE] = '{12'h100, 12'h108, 12'h10C};
  localparam logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000;

  // Command trigger
  localparam logic [11:0] CMD_OFF = 12'hF00;
  localparam logic [DATA_W-1:0] CMD_RST_A = 32'd1;
  localparam logic [DATA_W-1:0] CMD_RST_B = 32'd2;
  localparam logic [DATA_W-1:0] CMD_OFF_V = 32'd3;

  // Reset value of a storage word
  function automatic logic [DATA_W-1:0] preset_word(input int idx);
    case (idx)
      32'h40:  preset_word = 32'h05F2_0121;
      32'h41:  preset_word = 32'h0000_0002;
      32'h42:  preset_word = 32'h05F3_0121;
      32'h43:  preset_word = 32'h05F4_0121;
      default: preset_word = '0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 512,
  localparam int IDX_W = $clog2(WORDS),
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic              rd_en,
  output logic              oor,
  output logic              force_hit,
  output logic [IDX_W-1:0]  idx,
  output logic              bad_acc
);

  logic [WA_W-1:0] word_addr;
  logic [N_FORCE-1:0] force_vec;

  assign word_addr = addr[ADDR_W-1:2];
  assign oor       = {1'b0, word_addr} >= (WA_W+1)'(WORDS);
  assign idx       = word_addr[IDX_W-1:0];
  assign wr_en     = sel && we && !oor;
  assign rd_en     = sel && !we;

  for (genvar f = 0; f < N_FORCE; f++) begin : g_force
    assign force_vec[f] = (addr == ADDR_W'(FORCE_OFFS[f]));
  end
  assign force_hit = |force_vec;

  always_ff @(posedge clk) begin
    if (rst) bad_acc <= 1'b0;
    else     bad_acc <= sel && oor;
  end

  AST_BAD_ONLY_OOR: assert property (@(posedge clk) disable iff (rst)
    bad_acc |-> $past(addr[ADDR_W-1:2] >= WA_W'(WORDS))); // R3

  AST_BAD_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    bad_acc |-> $past(sel)); // R9

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int WORDS = 512,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              oor,
  input  logic              force_hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                mem[w] <= preset_word(w);
      else if (wr_en && idx == IDX_W'(w))     mem[w] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= oor ? '0 : (mem[idx] | (force_hit ? FORCE_MASK : '0));
  end

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rst_req,
  output logic              off_req
);

  logic cmd_wr;
  assign cmd_wr = sel && we && (addr == ADDR_W'(CMD_OFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      off_req <= 1'b0;
    end else begin
      rst_req <= cmd_wr && (wdata == CMD_RST_A || wdata == CMD_RST_B);
      off_req <= cmd_wr && (wdata == CMD_OFF_V);
    end
  end

  AST_RST_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(sel && we && addr == ADDR_W'(CMD_OFF))); // R5

  AST_OFF_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    off_req |-> $past(sel && we && wdata == CMD_OFF_V)); // R6

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && off_req)); // R6

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 512,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic              off_req,
  output logic              bad_acc
);

  logic             wr_en, rd_en, oor, force_hit;
  logic [IDX_W-1:0] idx;

  sysctl_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_dec (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .oor(oor), .force_hit(force_hit),
    .idx(idx), .bad_acc(bad_acc)
  );

  sysctl_store #(.WORDS(WORDS)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .oor(oor),
    .force_hit(force_hit), .idx(idx), .wdata(wdata), .rdata(rdata)
  );

  sysctl_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .rst_req(rst_req), .off_req(off_req)
  );

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_en && oor)) |-> (rdata == '0)); // R4

  AST_FORCE_BITS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_en && force_hit)) |-> (rdata[29:28] == 2'b11)); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!sel)) |-> $stable(rdata)); // R8

endmodule

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        we  = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, off_req, bad_acc;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sysctl_regbank dut_i (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req), .off_req(off_req), .bad_acc(bad_acc)
  );

  typedef struct {
    int          due;
    logic [31:0] exp_rd;
    logic        exp_rst;
    logic        exp_off;
    logic        exp_bad;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] model [NWORDS];
  logic [31:0] last_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NWORDS; i++) model[i] = 32'h0;
    model[32'h40] = 32'h05F2_0121;
    model[32'h41] = 32'h0000_0002;
    model[32'h42] = 32'h05F3_0121;
    model[32'h43] = 32'h05F4_0121;
    last_rd = 32'h0;
  endfunction

  // Driver: one bus cycle, expectation pushed for the following edge
  task automatic acc(input logic s, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input string tag);
    exp_t e;
    int   wi;
    @(posedge clk); #1;
    sel = s; we = w; addr = a; wdata = d;
    wi = int'(a >> 2);
    e.due = cyc + 1;
    e.tag = tag;
    e.exp_bad = s && (wi >= NWORDS);
    e.exp_rst = s && w && (a == 12'hF00) && (d == 32'd1 || d == 32'd2);
    e.exp_off = s && w && (a == 12'hF00) && (d == 32'd3);
    if (s && !w) begin
      if (wi >= NWORDS) last_rd = 32'h0;
      else if (a == 12'h100 || a == 12'h108 || a == 12'h10C)
        last_rd = model[wi] | 32'h3000_0000;
      else last_rd = model[wi];
    end
    if (s && w && wi < NWORDS) model[wi] = d;
    e.exp_rd = last_rd;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) acc(1'b0, 1'b0, 12'h000, 32'h0, "R8 idle");
  endtask

  // Monitor: compare at the falling edge after the sampling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " rdata"},   rdata,   e.exp_rd);
      chk({e.tag, " rst_req"}, {31'b0, rst_req}, {31'b0, e.exp_rst});
      chk({e.tag, " off_req"}, {31'b0, off_req}, {31'b0, e.exp_off});
      chk({e.tag, " bad_acc"}, {31'b0, bad_acc}, {31'b0, e.exp_bad});
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    sel = 0; we = 0; rst = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R2 reset rdata",   rdata, 32'h0);
    chk("R2 reset rst_req", {31'b0, rst_req}, 32'h0);
    chk("R2 reset off_req", {31'b0, off_req}, 32'h0);
    chk("R2 reset bad_acc", {31'b0, bad_acc}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    // R2 and R7: preset words and forced status bits
    acc(1, 0, 12'h100, 0, "R2 R7 rd 0x100");
    acc(1, 0, 12'h104, 0, "R2 R7 rd 0x104");
    acc(1, 0, 12'h108, 0, "R2 R7 rd 0x108");
    acc(1, 0, 12'h10C, 0, "R2 R7 rd 0x10C");
    acc(1, 0, 12'h000, 0, "R2 rd 0x000");
    acc(1, 0, 12'h7FC, 0, "R2 rd 0x7FC");
    // R1 and R9: in-range storage
    acc(1, 1, 12'h000, 32'hA5A5_0001, "R1 wr 0x000");
    acc(1, 1, 12'h7FC, 32'hDEAD_BEEF, "R1 wr 0x7FC");
    acc(1, 1, 12'h200, 32'h1234_5678, "R1 wr 0x200");
    acc(1, 0, 12'h000, 0, "R1 R9 rd 0x000");
    acc(1, 0, 12'h7FC, 0, "R1 R9 rd 0x7FC");
    acc(1, 0, 12'h200, 0, "R1 rd 0x200");
    // R7: mask on reads only
    acc(1, 1, 12'h100, 32'h0000_00FF, "R7 wr 0x100");
    acc(1, 0, 12'h100, 0, "R7 rd 0x100");
    acc(1, 1, 12'h104, 32'h0000_0005, "R7 wr 0x104");
    acc(1, 0, 12'h104, 0, "R7 rd 0x104 unmasked");
    acc(1, 1, 12'h10C, 32'hCFFF_FFFF, "R7 wr 0x10C");
    acc(1, 0, 12'h10C, 0, "R7 rd 0x10C");
    // R3 and R4: out of range
    acc(1, 1, 12'h800, 32'h1111_2222, "R3 wr 0x800");
    acc(1, 0, 12'h000, 0, "R3 rd 0x000 unchanged");
    acc(1, 1, 12'hFFC, 32'h3333_4444, "R3 wr 0xFFC");
    acc(1, 0, 12'h7FC, 0, "R3 rd 0x7FC unchanged");
    acc(1, 0, 12'h800, 0, "R4 rd 0x800");
    acc(1, 0, 12'h000, 0, "R1 rd 0x000 again");
    acc(1, 0, 12'hFFC, 0, "R4 rd 0xFFC");
    // R5 and R6: commands
    acc(1, 1, 12'hF00, 32'd1, "R5 cmd 1");
    acc(1, 1, 12'hF00, 32'd2, "R5 cmd 2 back-to-back");
    idle(1);
    acc(1, 1, 12'hF00, 32'd3, "R6 cmd 3");
    acc(1, 1, 12'hF00, 32'd0, "R6 cmd 0 none");
    acc(1, 1, 12'hF00, 32'd4, "R6 cmd 4 none");
    acc(1, 1, 12'hF04, 32'd1, "R6 wrong offset");
    acc(1, 0, 12'hF00, 0, "R4 rd cmd offset");
    acc(1, 1, 12'h080, 32'd3, "R6 in-range data 3");
    acc(0, 1, 12'hF00, 32'd1, "R8 unselected cmd");
    // R8: unselected cycles
    acc(1, 0, 12'h200, 0, "R8 load rdata");
    acc(0, 1, 12'h200, 32'hFFFF_FFFF, "R8 unselected wr");
    acc(0, 0, 12'h800, 0, "R8 unselected oor");
    acc(1, 1, 12'h204, 32'h0BAD_F00D, "R8 hold across write");
    acc(1, 0, 12'h200, 0, "R8 rd 0x200 unchanged");
    acc(1, 0, 12'h080, 0, "R1 rd 0x080");
    idle(3);
    // R2: reset in the middle of the run
    do_reset();
    acc(1, 0, 12'h000, 0, "R2 rd 0x000 cleared");
    acc(1, 0, 12'h104, 0, "R2 rd 0x104 preset");
    acc(1, 0, 12'h108, 0, "R2 R7 rd 0x108 preset");
    idle(3);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
    finish_run();
  end

endmodule